// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of external input pins and turns selected level transitions into interrupt requests. For each channel, software picks rising edges, falling edges, or both. An event sets a sticky status bit. Software clears that bit by writing a one to it. A channel takes part in an interrupt request only when two conditions hold: its request-enable bit is set, and its route bit selects interrupt rather than DMA. The pending channels are split into fixed groups of eight, and each group drives its own interrupt output.

Every pin passes through a two-flop synchronizer. After that, a channel can switch in a glitch filter. The filter runs on ticks from a shared prescaler. It moves its output level only after the synchronized input has held a new value for a programmable number of consecutive ticks. All configuration sits behind a simple 32-bit word-addressed register bus. Writes take effect on the clock edge and reads are combinational.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset every register reads 0 and all interrupt outputs are 0.
- R2: With the channel's bit set in the rising-enable register (offset 0x18, bit n = channel n), a 0-to-1 pin transition sets bit n of the status register (offset 0x00).
- R3: With the channel's bit set in the falling-enable register (0x20), a 1-to-0 transition sets its status bit. With both enables set, both directions set it.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits never fall without such a write.
- R5: Interrupt output g is high when any channel in 8g..8g+7 has both its status bit and its request-enable bit (0x08) set, and its route bit is 0.
- R6: A route bit of 1 (register 0x10) removes the channel from the interrupt outputs, and its status bit still sets.
- R7: When the channel's bit in the filter-enable register (0x28) is 1, a new level passes only after it has held for MAXCNT+1 consecutive filter ticks. MAXCNT is bits [3:0] at 0x30+4n. Any return to the old level restarts the count. When the bit is 0, the filter is bypassed.
- R8: The prescaler field (bits [3:0] at 0xB0) gives one filter tick every 2^value clocks.
- R9: When an edge event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Reads of unmapped word offsets return 0. The max-count and prescaler registers read back only their 4-bit fields.
- R11: With the filter bypassed, the status bit becomes visible after the third rising clock edge that follows the pin change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | External interrupt pins, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| irq_o | output | NUM_CH/GRP_SZ | Group interrupt requests |

## Verification
Two things can land on the same status bit in one clock: a freshly detected edge, and a software write-one-to-clear. The bench sets this up by raising a pin and then asserting the clearing write so that it is registered on exactly the third edge, which is the edge where the event is latched. The bit must read back as 1. A plain clear that follows must then empty it. That result is judged at the bus, and an in-design property checks that every latched event survives a clear issued in the same cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    // Register byte offsets (word aligned)
    localparam int OFS_STATUS = 'h00;
    localparam int OFS_REQEN  = 'h08;
    localparam int OFS_ROUTE  = 'h10;
    localparam int OFS_RISE   = 'h18;
    localparam int OFS_FALL   = 'h20;
    localparam int OFS_FILT   = 'h28;
    localparam int OFS_MAXC   = 'h30;
    localparam int OFS_PRESC  = 'hB0;
endpackage

// File: rtl/eirq_tick_gen.sv
module eirq_tick_gen #(
    parameter int P_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] presc_i,
    output logic           tick_o
);
    localparam int CW = (1 << P_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q, mask;

    always_comb begin
        mask   = ~({CW{1'b1}} << presc_i);
        tick_o = (cnt_q >= mask);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_i == '0) |-> tick_o); // R8
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             tick_i,
    input  logic             filt_en_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             rise_en_i,
    input  logic             fall_en_i,
    output logic             evt_o
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     level;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        level   = filt_en_i ? st_q.lvl : st_q.s2;
        if (!filt_en_i) begin
            st_d.lvl = st_q.s2;
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.s2 != st_q.lvl) begin
                if (st_q.cnt >= max_i) begin
                    st_d.lvl = st_q.s2;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
        st_d.prev = level;
        evt_o = (rise_en_i & level & ~st_q.prev) | (fall_en_i & ~level & st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FILT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en_i && !tick_i) |=> (st_q.lvl == $past(st_q.lvl))); // R7
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int GRP_SZ = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        pin_i,
    input  logic                     bus_wr_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    output logic [NUM_CH/GRP_SZ-1:0] irq_o
);
    localparam int NUM_GRP = NUM_CH / GRP_SZ;

    typedef struct packed {
        logic [NUM_CH-1:0]            status;
        logic [NUM_CH-1:0]            reqen;
        logic [NUM_CH-1:0]            route;
        logic [NUM_CH-1:0]            rise;
        logic [NUM_CH-1:0]            fall;
        logic [NUM_CH-1:0]            filt;
        logic [NUM_CH-1:0][CNT_W-1:0] maxc;
        logic [CNT_W-1:0]             presc;
    } regs_t;

    regs_t             r_d, r_q;
    logic              tick;
    logic [NUM_CH-1:0] evt, clr, pend;
    logic              wr_status;

    eirq_tick_gen #(.P_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .presc_i(r_q.presc),
        .tick_o (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        eirq_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_i[c]),
            .tick_i   (tick),
            .filt_en_i(r_q.filt[c]),
            .max_i    (r_q.maxc[c]),
            .rise_en_i(r_q.rise[c]),
            .fall_en_i(r_q.fall[c]),
            .evt_o    (evt[c])
        );
    end

    assign wr_status = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STATUS));

    always_comb begin
        r_d = r_q;
        clr = wr_status ? bus_wdata_i[NUM_CH-1:0] : '0;
        if (bus_wr_i) begin
            case (bus_addr_i)
                ADDR_W'(OFS_REQEN): r_d.reqen = bus_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_ROUTE): r_d.route = bus_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_RISE):  r_d.rise  = bus_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_FALL):  r_d.fall  = bus_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_FILT):  r_d.filt  = bus_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_PRESC): r_d.presc = bus_wdata_i[CNT_W-1:0];
                default: ;
            endcase
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr_i == ADDR_W'(OFS_MAXC + 4 * i))
                    r_d.maxc[i] = bus_wdata_i[CNT_W-1:0];
            end
        end
        // a fresh event overrides a clear in the same cycle
        r_d.status = (r_q.status & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(OFS_STATUS): bus_rdata_o = DATA_W'(r_q.status);
            ADDR_W'(OFS_REQEN):  bus_rdata_o = DATA_W'(r_q.reqen);
            ADDR_W'(OFS_ROUTE):  bus_rdata_o = DATA_W'(r_q.route);
            ADDR_W'(OFS_RISE):   bus_rdata_o = DATA_W'(r_q.rise);
            ADDR_W'(OFS_FALL):   bus_rdata_o = DATA_W'(r_q.fall);
            ADDR_W'(OFS_FILT):   bus_rdata_o = DATA_W'(r_q.filt);
            ADDR_W'(OFS_PRESC):  bus_rdata_o = DATA_W'(r_q.presc);
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr_i == ADDR_W'(OFS_MAXC + 4 * i))
                bus_rdata_o = DATA_W'(r_q.maxc[i]);
        end
    end

    assign pend = r_q.status & r_q.reqen & ~r_q.route;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign irq_o[g] = |pend[g*GRP_SZ +: GRP_SZ];
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ((r_q.status & r_q.reqen) != '0)); // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((r_q.status & $past(r_q.status)) == $past(r_q.status))); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((r_q.status & $past(bus_wdata_i[NUM_CH-1:0] & ~evt)) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.status & $past(evt)) == $past(evt))); // R9
endmodule

// File: tb/sim_eirq_ctrl.sv
module sim_eirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    eirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic clear_all();
        wr(8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 'hB0; a += 8) begin
            rd(a[7:0], v);
            check("R1 reg reset", v, 32'h0);
        end
        check("R1 irq reset", {28'h0, irq}, 32'h0);
    endtask

    task automatic t_rise_latency();
        logic [31:0] v;
        wr(8'h18, 32'h1 << 3);
        pin[3] = 1'b1;
        cyc(2);
        rd(8'h00, v);
        check("R11 not after 2nd edge", v, 32'h0);
        cyc(1);
        rd(8'h00, v);
        check("R11/R2 rising sets bit 3", v, 32'h8);
        check("R5 no irq without enable", {28'h0, irq}, 32'h0);
        pin[3] = 1'b0;
        cyc(5);
        rd(8'h00, v);
        check("R2 falling ignored on rise-only", v, 32'h8);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        wr(8'h20, (32'h1 << 9) | (32'h1 << 10));
        wr(8'h18, (32'h1 << 10));
        pin[9] = 1'b1;
        cyc(5);
        rd(8'h00, v);
        check("R3 rising ignored on fall-only", v, 32'h8);
        pin[9] = 1'b0;
        cyc(5);
        rd(8'h00, v);
        check("R3 falling sets bit 9", v, 32'h208);
        pin[10] = 1'b1;
        cyc(5);
        rd(8'h00, v);
        check("R3 both: rise sets bit 10", v, 32'h608);
        wr(8'h00, 32'h1 << 10);
        pin[10] = 1'b0;
        cyc(5);
        rd(8'h00, v);
        check("R3 both: fall sets bit 10", v, 32'h608);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(8'h00, 32'h0);
        rd(8'h00, v);
        check("R4 zero write no effect", v, 32'h608);
        wr(8'h00, 32'h8);
        rd(8'h00, v);
        check("R4 one clears only bit 3", v, 32'h600);
        clear_all();
        rd(8'h00, v);
        check("R4 clear all", v, 32'h0);
    endtask

    task automatic t_irq_route();
        logic [31:0] v;
        wr(8'h18, (32'h1 << 17) | (32'h1 << 5));
        wr(8'h08, 32'h1 << 17);
        pin[5] = 1'b1;
        cyc(5);
        check("R5 unenabled channel no irq", {28'h0, irq}, 32'h0);
        pin[17] = 1'b1;
        cyc(5);
        check("R5 group 2 irq", {28'h0, irq}, 32'h4);
        wr(8'h10, 32'h1 << 17);
        check("R6 routed away no irq", {28'h0, irq}, 32'h0);
        rd(8'h00, v);
        check("R6 status still set", v, (32'h1 << 17) | (32'h1 << 5));
        wr(8'h10, 32'h0);
        check("R6 route back irq", {28'h0, irq}, 32'h4);
        clear_all();
        check("R5 irq drops after clear", {28'h0, irq}, 32'h0);
        wr(8'h08, 32'h0);
    endtask

    task automatic pulse(input int ch, input int n);
        @(negedge clk);
        pin[ch] = 1'b1;
        cyc(n);
        pin[ch] = 1'b0;
        cyc(12);
    endtask

    task automatic t_filter();
        logic [31:0] v;
        wr(8'h18, (32'h1 << 20) | (32'h1 << 21));
        wr(8'h28, 32'h1 << 20);
        wr(8'h30 + 8'd80, 32'h3);
        pulse(20, 3);
        rd(8'h00, v);
        check("R7 3-tick glitch rejected", v, 32'h0);
        pulse(21, 1);
        rd(8'h00, v);
        check("R7 bypass passes 1-cycle pulse", v, 32'h1 << 21);
        clear_all();
        pulse(20, 10);
        rd(8'h00, v);
        check("R7 held level passes", v, 32'h1 << 20);
        clear_all();
    endtask

    task automatic t_presc();
        logic [31:0] v;
        wr(8'h30 + 8'd80, 32'h1);
        pulse(20, 3);
        rd(8'h00, v);
        check("R8 prescale 0 passes 3 cycles", v, 32'h1 << 20);
        clear_all();
        wr(8'hB0, 32'h2);
        pulse(20, 3);
        rd(8'h00, v);
        check("R8 prescale 2 rejects 3 cycles", v, 32'h0);
        pulse(20, 20);
        rd(8'h00, v);
        check("R8 prescale 2 passes 20 cycles", v, 32'h1 << 20);
        clear_all();
        wr(8'h28, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(8'h18, 32'h1 << 25);
        @(negedge clk);
        pin[25] = 1'b1;
        cyc(2);
        bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h1 << 25;
        cyc(1);
        bus_wr = 1'b0;
        rd(8'h00, v);
        check("R9 set wins over clear", v, 32'h1 << 25);
        clear_all();
        rd(8'h00, v);
        check("R4 later clear works", v, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v);
        check("R10 unmapped 0x04 reads 0", v, 32'h0);
        rd(8'hB4, v);
        check("R10 unmapped 0xB4 reads 0", v, 32'h0);
        wr(8'hB0, 32'hFFFF_FFF5);
        rd(8'hB0, v);
        check("R10 prescaler field only", v, 32'h5);
        wr(8'hAC, 32'h37);
        rd(8'hAC, v);
        check("R10 max count field only", v, 32'h7);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_rise_latency();
        t_fall_both();
        t_w1c();
        t_irq_route();
        t_filter();
        t_presc();
        t_race();
        t_map();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule